// File: doc/BRIEF.md
# Processor State and Power-Mode Controller

This block holds the top-level operating state of a small embedded processor core and the privilege bit that goes with it. On every clock it samples the reset, standby, sleep, interrupt, exception and bus-request levels and strobes. It picks the one transition that applies under a fixed precedence and registers the new state. From that state it derives a clock-stop indication for the clock generator and a bus-grant indication for the external bus arbiter.

The reset levels, the hardware-standby level and the bus request are all plain levels. The sleep, exception and end-of-exception inputs are single-cycle strobes. An interrupt request is a level that is sampled every cycle. No input or output carries a data stream, so there is no valid/ready handshake. Every pin is a plain control or status signal, and all inputs are sampled on the rising clock edge. Each output reflects a transition one clock after the edge at which its cause was sampled.

Top module: `pstate_ctrl`

## Requirements
- R1: When `stby_n_i` is low at a clock edge, the next state is hardware standby (code 7) from any state, whatever the other inputs are.
- R2: Hardware standby is left only when `stby_n_i` is high and `por_n_i` is low, and then it goes to power-on reset (code 0). With both of them high, the controller stays in hardware standby.
- R3: With `stby_n_i` high, a low `por_n_i` moves any state other than hardware standby to power-on reset (code 0). This includes the case where `mrst_n_i` is low at the same time.
- R4: With `stby_n_i` and `por_n_i` high, a low `mrst_n_i` moves any state to manual reset (code 1), except bus-released (code 4). In bus-released the low level is ignored.
- R5: In either reset state, once `stby_n_i`, `por_n_i` and `mrst_n_i` are all high, the next state is exception handling (code 3).
- R6: A `sleep_i` strobe in program execution (code 2) moves to sleep (code 5) when `sleep_stby_i` is 0, and to software standby (code 6) when it is 1. In every other state the strobe is ignored.
- R7: `irq_i` moves sleep or software standby to exception handling. In program execution, `exc_i` or `irq_i` moves to exception handling. In exception handling, `eoe_i` returns to program execution.
- R8: A high `bus_req_i` moves program execution or sleep to bus-released. When the request clears, the controller returns to exactly the state it left. A bus request in software standby or exception handling is ignored.
- R9: In program execution, exception or interrupt wins over a bus request, and a bus request wins over a sleep strobe.
- R10: `priv_o` becomes 1 whenever the state entered is power-on reset, manual reset or exception handling. It becomes 0 on the step from exception handling to program execution. Otherwise it holds.
- R11: `clk_stop_o` is high exactly in sleep, software standby and hardware standby. `bus_grant_o` is high exactly in bus-released.
- R12: `state_o` uses the codes given above, and `state_o` and `priv_o` change one clock after the edge that sampled their cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset level, active low |
| mrst_n_i | input | 1 | Manual reset level, active low |
| stby_n_i | input | 1 | Hardware standby request level, active low |
| sleep_i | input | 1 | Sleep instruction strobe |
| sleep_stby_i | input | 1 | Standby select for the sleep strobe (1 = software standby) |
| irq_i | input | 1 | Interrupt request level |
| exc_i | input | 1 | Exception strobe |
| eoe_i | input | 1 | End-of-exception strobe |
| bus_req_i | input | 1 | External bus request level |
| state_o | output | 3 | Encoded current state |
| priv_o | output | 1 | Privilege bit (1 = privileged) |
| clk_stop_o | output | 1 | Core clock stop indication |
| bus_grant_o | output | 1 | Bus released to the external master |

## Verification
Every internal fault of this controller surfaces on `state_o` one clock after the edge that caused it. The bench therefore compares the encoded state, the privilege bit and both indications on every cycle against a behavioural model, and a wrong transition cannot stay hidden for more than one cycle. The return register is the exception. A wrong capture is visible only when the bus request clears, so the bench clears requests from both sleep and program execution. The privilege bit can also hold a stale value through several states. It is therefore checked on entry to every state that must set it and on the one step that must clear it.

// File: rtl/pstate_pkg.sv
package pstate_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PS_POR    = 3'd0,
    PS_MRST   = 3'd1,
    PS_EXEC   = 3'd2,
    PS_EXCP   = 3'd3,
    PS_BUSREL = 3'd4,
    PS_SLEEP  = 3'd5,
    PS_SSTBY  = 3'd6,
    PS_HSTBY  = 3'd7
  } pstate_e;

  typedef struct packed {
    logic por_n;
    logic mrst_n;
    logic stby_n;
    logic sleep;
    logic sleep_stby;
    logic irq;
    logic exc;
    logic eoe;
    logic bus_req;
  } preq_t;
endpackage

// File: rtl/pstate_next.sv
module pstate_next
  import pstate_pkg::*;
(
  input  pstate_e cur_i,
  input  pstate_e saved_i,
  input  preq_t   req_i,
  output pstate_e nxt_o,
  output logic    save_en_o
);
  logic resets_free;
  assign resets_free = req_i.por_n && req_i.mrst_n;

  always_comb begin
    nxt_o     = cur_i;
    save_en_o = 1'b0;
    if (!req_i.stby_n) begin
      nxt_o = PS_HSTBY;
    end else if (cur_i == PS_HSTBY) begin
      if (!req_i.por_n) nxt_o = PS_POR;
    end else if (!req_i.por_n) begin
      nxt_o = PS_POR;
    end else if (!req_i.mrst_n && cur_i != PS_BUSREL) begin
      nxt_o = PS_MRST;
    end else begin
      unique case (cur_i)
        PS_POR, PS_MRST: begin
          if (resets_free) nxt_o = PS_EXCP;
        end
        PS_EXEC: begin
          if (req_i.exc || req_i.irq) begin
            nxt_o = PS_EXCP;
          end else if (req_i.bus_req) begin
            nxt_o     = PS_BUSREL;
            save_en_o = 1'b1;
          end else if (req_i.sleep) begin
            nxt_o = req_i.sleep_stby ? PS_SSTBY : PS_SLEEP;
          end
        end
        PS_SLEEP: begin
          if (req_i.irq) begin
            nxt_o = PS_EXCP;
          end else if (req_i.bus_req) begin
            nxt_o     = PS_BUSREL;
            save_en_o = 1'b1;
          end
        end
        PS_SSTBY: begin
          if (req_i.irq) nxt_o = PS_EXCP;
        end
        PS_EXCP: begin
          if (req_i.eoe) nxt_o = PS_EXEC;
        end
        PS_BUSREL: begin
          if (!req_i.bus_req) nxt_o = saved_i;
        end
        default: nxt_o = cur_i;
      endcase
    end
  end
endmodule

// File: rtl/pstate_resume.sv
module pstate_resume
  import pstate_pkg::*;
(
  input  logic    clk,
  input  logic    por_n_i,
  input  logic    save_en_i,
  input  pstate_e cur_i,
  output pstate_e saved_o
);
  pstate_e saved_q;

  always_ff @(posedge clk) begin
    if (save_en_i) saved_q <= cur_i;
  end

  assign saved_o = saved_q;

  // R8: only program execution or sleep can be the state a bus release returns to
  p_save_src_r8: assert property (@(posedge clk) disable iff (!por_n_i)
    save_en_i |-> (cur_i == PS_EXEC || cur_i == PS_SLEEP));
endmodule

// File: rtl/pstate_priv.sv
module pstate_priv
  import pstate_pkg::*;
(
  input  logic    clk,
  input  logic    por_n_i,
  input  pstate_e cur_i,
  input  pstate_e nxt_i,
  output logic    priv_o
);
  logic priv_q;
  logic set_c;
  logic clr_c;

  assign set_c = (nxt_i == PS_POR) || (nxt_i == PS_MRST) || (nxt_i == PS_EXCP);
  assign clr_c = (cur_i == PS_EXCP) && (nxt_i == PS_EXEC);

  always_ff @(posedge clk) begin
    if (set_c)      priv_q <= 1'b1;
    else if (clr_c) priv_q <= 1'b0;
  end

  assign priv_o = priv_q;

  // R10: privilege is held while the state does not change
  p_priv_hold_r10: assert property (@(posedge clk) disable iff (!por_n_i)
    (nxt_i == cur_i && cur_i != PS_POR && cur_i != PS_MRST && cur_i != PS_EXCP)
    |=> $stable(priv_q));
endmodule

// File: rtl/pstate_ctrl.sv
module pstate_ctrl
  import pstate_pkg::*;
(
  input  logic               clk,
  input  logic               por_n_i,
  input  logic               mrst_n_i,
  input  logic               stby_n_i,
  input  logic               sleep_i,
  input  logic               sleep_stby_i,
  input  logic               irq_i,
  input  logic               exc_i,
  input  logic               eoe_i,
  input  logic               bus_req_i,
  output logic [STATE_W-1:0] state_o,
  output logic               priv_o,
  output logic               clk_stop_o,
  output logic               bus_grant_o
);
  preq_t   req;
  pstate_e state_q;
  pstate_e nxt;
  pstate_e saved;
  logic    save_en;

  assign req = '{por_n: por_n_i, mrst_n: mrst_n_i, stby_n: stby_n_i,
                 sleep: sleep_i, sleep_stby: sleep_stby_i, irq: irq_i,
                 exc: exc_i, eoe: eoe_i, bus_req: bus_req_i};

  pstate_next u_next (
    .cur_i     (state_q),
    .saved_i   (saved),
    .req_i     (req),
    .nxt_o     (nxt),
    .save_en_o (save_en)
  );

  pstate_resume u_resume (
    .clk       (clk),
    .por_n_i   (por_n_i),
    .save_en_i (save_en),
    .cur_i     (state_q),
    .saved_o   (saved)
  );

  pstate_priv u_priv (
    .clk     (clk),
    .por_n_i (por_n_i),
    .cur_i   (state_q),
    .nxt_i   (nxt),
    .priv_o  (priv_o)
  );

  always_ff @(posedge clk) begin
    state_q <= nxt;
  end

  assign state_o     = state_q;
  assign clk_stop_o  = (state_q == PS_SLEEP) || (state_q == PS_SSTBY) ||
                       (state_q == PS_HSTBY);
  assign bus_grant_o = (state_q == PS_BUSREL);

  p_hstby_r1: assert property (@(posedge clk) disable iff (!por_n_i)
    !stby_n_i |=> state_o == PS_HSTBY);

  p_hstby_stay_r2: assert property (@(posedge clk) disable iff (!por_n_i)
    (state_o == PS_HSTBY) |=> (state_o == PS_HSTBY));

  p_mrst_r4: assert property (@(posedge clk) disable iff (!por_n_i)
    (stby_n_i && !mrst_n_i && state_o != PS_BUSREL && state_o != PS_HSTBY)
    |=> (state_o == PS_MRST && priv_o));

  p_excp_exit_r10: assert property (@(posedge clk) disable iff (!por_n_i)
    (stby_n_i && mrst_n_i && state_o == PS_EXCP && eoe_i)
    |=> (state_o == PS_EXEC && !priv_o));

  p_resume_r8: assert property (@(posedge clk) disable iff (!por_n_i)
    (stby_n_i && state_o == PS_BUSREL && !bus_req_i)
    |=> (state_o == $past(saved)));

  p_ind_r11: assert property (@(posedge clk) disable iff (!por_n_i)
    $onehot0({clk_stop_o, bus_grant_o}));
endmodule

// File: tb/pstate_ctrl_tb.sv
module pstate_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic por_n = 1'b0, mrst_n = 1'b1, stby_n = 1'b1;
  logic sleep = 1'b0, sleep_stby = 1'b0, irq = 1'b0, exc = 1'b0, eoe = 1'b0, bus_req = 1'b0;
  logic [2:0] state_o;
  logic priv_o, clk_stop_o, bus_grant_o;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R3";

  int m_state = 0;
  int m_saved = 0;
  int m_priv  = 0;
  bit started = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pstate_ctrl u_dut (
    .clk(clk), .por_n_i(por_n), .mrst_n_i(mrst_n), .stby_n_i(stby_n),
    .sleep_i(sleep), .sleep_stby_i(sleep_stby), .irq_i(irq), .exc_i(exc),
    .eoe_i(eoe), .bus_req_i(bus_req), .state_o(state_o), .priv_o(priv_o),
    .clk_stop_o(clk_stop_o), .bus_grant_o(bus_grant_o)
  );

  // behavioural reference: 0 por, 1 mrst, 2 exec, 3 excp, 4 busrel, 5 sleep, 6 sstby, 7 hstby
  always @(posedge clk) begin
    int n;
    n = m_state;
    if (!stby_n) n = 7;
    else if (m_state == 7) n = por_n ? 7 : 0;
    else if (!por_n) n = 0;
    else if (!mrst_n && m_state != 4) n = 1;
    else if ((m_state == 0 || m_state == 1) && mrst_n) n = 3;
    else if (m_state == 2) begin
      if (exc || irq) n = 3;
      else if (bus_req) begin n = 4; m_saved = 2; end
      else if (sleep) n = sleep_stby ? 6 : 5;
    end
    else if (m_state == 5) begin
      if (irq) n = 3;
      else if (bus_req) begin n = 4; m_saved = 5; end
    end
    else if (m_state == 6 && irq) n = 3;
    else if (m_state == 3 && eoe) n = 2;
    else if (m_state == 4 && !bus_req) n = m_saved;
    if (n == 0 || n == 1 || n == 3) m_priv = 1;
    else if (m_state == 3 && n == 2) m_priv = 0;
    m_state = n;
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started) begin
      bit exp_stop, exp_grant;
      exp_stop  = (m_state == 5 || m_state == 6 || m_state == 7);
      exp_grant = (m_state == 4);
      n_cmp++;
      if (int'(state_o) != m_state || int'(priv_o) != m_priv ||
          clk_stop_o != exp_stop || bus_grant_o != exp_grant) begin
        n_bad++;
        $display("FAIL %s/R12/R11: state=%0d priv=%0d stop=%0d grant=%0d expected state=%0d priv=%0d stop=%0d grant=%0d",
                 cur_req, state_o, priv_o, clk_stop_o, bus_grant_o,
                 m_state, m_priv, exp_stop, exp_grant);
      end
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic pulse_clear();
    sleep = 0; exc = 0; eoe = 0;
  endtask

  task automatic expect_st(int exp_s, int exp_p, string tag);
    n_cmp++;
    if (int'(state_o) != exp_s || int'(priv_o) != exp_p) begin
      n_bad++;
      $display("FAIL %s: state=%0d priv=%0d expected state=%0d priv=%0d",
               tag, state_o, priv_o, exp_s, exp_p);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R3: power-on reset wins over manual reset
    cur_req = "R3";
    mrst_n = 0;
    step(3);
    expect_st(0, 1, "R3 reset state");
    n_cmp++;
    if (clk_stop_o || bus_grant_o) begin
      n_bad++;
      $display("FAIL R11: stop=%0d grant=%0d expected 0 0", clk_stop_o, bus_grant_o);
    end
    por_n = 1; step(1);
    expect_st(1, 1, "R4 mrst after por release");
    // R5: release of both resets
    cur_req = "R5";
    mrst_n = 1; step(1);
    expect_st(3, 1, "R5 reset release to exception");
    cur_req = "R7";
    eoe = 1; step(1); pulse_clear();
    expect_st(2, 0, "R10 exception end clears priv");
    eoe = 1; step(1); pulse_clear();
    expect_st(2, 0, "R7 eoe ignored in exec");
    // R6 sleep, R8 bus from sleep
    cur_req = "R6";
    sleep = 1; sleep_stby = 0; step(1); pulse_clear();
    expect_st(5, 0, "R6 sleep mode");
    cur_req = "R8";
    bus_req = 1; step(3);
    expect_st(4, 0, "R8 released from sleep");
    bus_req = 0; step(1);
    expect_st(5, 0, "R8 return to sleep");
    cur_req = "R7";
    irq = 1; step(1); irq = 0;
    expect_st(3, 1, "R7 irq wakes sleep");
    eoe = 1; step(1); pulse_clear();
    // software standby, bus request ignored there
    cur_req = "R6";
    sleep = 1; sleep_stby = 1; step(1); pulse_clear();
    expect_st(6, 0, "R6 software standby");
    cur_req = "R8";
    bus_req = 1; step(2); bus_req = 0;
    expect_st(6, 0, "R8 bus ignored in software standby");
    irq = 1; step(1); irq = 0;
    expect_st(3, 1, "R7 irq wakes software standby");
    cur_req = "R6";
    sleep = 1; sleep_stby = 0; step(1); pulse_clear();
    expect_st(3, 1, "R6 sleep ignored in exception");
    eoe = 1; step(1); pulse_clear();
    // R9 priority in exec
    cur_req = "R9";
    exc = 1; bus_req = 1; sleep = 1; step(1); pulse_clear();
    expect_st(3, 1, "R9 exception over bus and sleep");
    bus_req = 0; eoe = 1; step(1); pulse_clear();
    bus_req = 1; sleep = 1; step(1); pulse_clear();
    expect_st(4, 0, "R9 bus over sleep");
    // R4 manual reset blocked in bus-released
    cur_req = "R4";
    mrst_n = 0; step(2);
    expect_st(4, 0, "R4 mrst ignored in bus-released");
    bus_req = 0; step(1);
    expect_st(2, 0, "R8 return to exec");
    step(1);
    expect_st(1, 1, "R4 mrst from exec");
    mrst_n = 1; step(1);
    expect_st(3, 1, "R5 mrst release");
    eoe = 1; step(1); pulse_clear();
    // R1/R2 hardware standby
    cur_req = "R1";
    stby_n = 0; por_n = 0; mrst_n = 0; step(1);
    expect_st(7, 0, "R1 standby over resets");
    cur_req = "R2";
    por_n = 1; mrst_n = 1; stby_n = 1; irq = 1; step(2); irq = 0;
    expect_st(7, 0, "R2 standby held with por high");
    n_cmp++;
    if (!clk_stop_o) begin
      n_bad++;
      $display("FAIL R11: stop=%0d expected 1", clk_stop_o);
    end
    por_n = 0; step(1);
    expect_st(0, 1, "R2 exit to power-on reset");
    por_n = 1; step(1);
    expect_st(3, 1, "R5 after standby exit");
    eoe = 1; step(1); pulse_clear();
    cur_req = "R1";
    sleep = 1; sleep_stby = 1; step(1); pulse_clear();
    stby_n = 0; step(1);
    expect_st(7, 0, "R1 standby from software standby");
    stby_n = 1; por_n = 0; step(1); por_n = 1; step(2);
    cur_req = "R12";
    step(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule